// File: doc/BRIEF.md
# IPv4 Header Check and Forward Engine

This engine takes one packet at a time from a merged input queue. Each packet arrives as the base address of its header in packet memory. The engine copies the five 32-bit words of an option-free IPv4 header into a small local store. While the copy runs, it checks the version/length byte and forms the ones'-complement header sum. It does this by reading back words already stored through the store's asynchronous read port while the synchronous write port takes the next word. After the copy it checks the TTL, optionally screens the source address against a block list, and looks the destination up in an exact-match route table.

A packet that passes every check has its TTL decremented and a fresh checksum written back to the local store. The engine then issues one result naming port A or port B. The new checksum comes from a second running sum that leaves out the TTL/protocol/checksum word, so only the new TTL/protocol half has to be folded in. A packet that fails any check is sent to the discard output. The engine reports the result as a one-cycle pulse carrying the destination code, the base address, and the updated TTL/protocol/checksum word read out of the local store.

Top module: `ipv4_fwd_engine`

## Requirements
- R1: `in_ready` is high when the engine is idle and out of reset. A header is accepted on a cycle with `in_valid` and `in_ready` both high. The engine then reads packet memory words `base+0` to `base+4` in order, one per cycle, and read data is expected one cycle after `pkt_rd_en`.
- R2: The top byte of header word 0 must be 0x45 (version 4, five-word header). Any other value sends the packet to discard after only the single read of word 0, and `out_valid` rises one cycle after the accepting edge.
- R3: The header is valid only if the 16-bit ones'-complement sum, with end-around carry, of all ten header halves equals 0xFFFF. Otherwise the packet is discarded.
- R4: A TTL (bits 31:24 of word 2) of 0 or 1 discards the packet. A TTL of 2 or more passes.
- R5: The destination address (word 4) is compared exactly against every valid route entry. The lowest-index hit selects port A when that entry's port bit is 0 and port B when it is 1. A miss discards the packet.
- R6: With `cfg_filter_en` high, a source address (word 3) equal to any valid block-list entry discards the packet. With it low, the block list has no effect.
- R7: For a forwarded packet, `out_hdr_w2` equals {TTL-1, protocol, C}. C is the bitwise inverse of the ones'-complement sum of the halves of words 0, 1, 3, 4 and of {TTL-1, protocol}.
- R8: `out_dest` is 2'b00 for port A, 2'b01 for port B and 2'b10 for discard; 2'b11 never appears. `out_valid` is a single-cycle pulse, and `out_addr` carries the accepted base address.
- R9: `out_valid` rises 9 cycles after the accepting edge for a forwarded packet and 7 cycles after it for a packet discarded by the checksum, TTL, filter or route checks. Enabling the filter does not change either figure.
- R10: The local store is never read at the word it is writing in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A header base address is offered |
| in_addr | input | ADDR_W | Header base address in packet memory |
| in_ready | output | 1 | Engine idle and able to accept |
| pkt_rd_en | output | 1 | Packet memory read strobe |
| pkt_rd_addr | output | ADDR_W | Packet memory word address |
| pkt_rd_data | input | 32 | Packet memory data, one cycle after the strobe |
| cfg_filter_en | input | 1 | Enables the source block list |
| cfg_route_key | input | RT_N*32 | Route table destination addresses |
| cfg_route_port | input | RT_N | Route table port bit per entry (0 = A, 1 = B) |
| cfg_route_vld | input | RT_N | Route entry valid bits |
| cfg_block_key | input | BL_N*32 | Blocked source addresses |
| cfg_block_vld | input | BL_N | Block entry valid bits |
| out_valid | output | 1 | One-cycle result pulse |
| out_dest | output | 2 | Destination code |
| out_addr | output | ADDR_W | Base address of the finished header |
| out_hdr_w2 | output | 32 | TTL/protocol/checksum word from the local store |

## Verification
The assertions assume that packet memory answers every read strobe with data on the following cycle. They also assume that `in_valid` stays low while reset is active, since the early-reject property keys on the cycle after an acceptance. The stimulus holds configuration inputs steady while a header is in flight and changes them only between packets. The packet memory model in the bench returns registered data exactly one cycle after each strobe.

// File: rtl/ipv4_fwd_pkg.sv
package ipv4_fwd_pkg;

  localparam int HDR_WORDS = 5;
  localparam int CSUM_WORD = 2;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FETCH,
    S_SUM,
    S_CHECK,
    S_WB_TTL,
    S_WB_CSUM,
    S_DONE
  } fwd_state_t;

  typedef enum logic [1:0] {
    DEST_A    = 2'b00,
    DEST_B    = 2'b01,
    DEST_DROP = 2'b10
  } dest_t;

  // 16-bit ones'-complement add with end-around carry
  function automatic logic [15:0] oc_add(input logic [15:0] a, input logic [15:0] b);
    logic [16:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[15:0] + {15'd0, s[16]};
  endfunction

endpackage

// File: rtl/fwd_rst_sync.sv
module fwd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/hdr_store.sv
module hdr_store #(
  parameter int DW    = 32,
  parameter int DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [DW/8-1:0]          be,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [DW-1:0]            wdata,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [DW-1:0]            rdata
);

  localparam int LANES = DW / 8;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    for (int b = 0; b < LANES; b++) begin
      if (we && be[b]) mem_q[waddr][8*b +: 8] <= wdata[8*b +: 8];
    end
  end

  assign rdata = mem_q[raddr];

endmodule

// File: rtl/match_table.sv
module match_table #(
  parameter int N = 8,
  parameter int W = 32
) (
  input  logic [W-1:0]   key,
  input  logic [N*W-1:0] entry_key,
  input  logic [N-1:0]   entry_vld,
  output logic [N-1:0]   match
);

  for (genvar g = 0; g < N; g++) begin : g_line
    assign match[g] = entry_vld[g] && (key == entry_key[g*W +: W]);
  end

endmodule

// File: rtl/ipv4_fwd_engine.sv
module ipv4_fwd_engine
  import ipv4_fwd_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int RT_N        = 8,
  parameter int BL_N        = 4,
  parameter int STORE_DEPTH = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [ADDR_W-1:0]  in_addr,
  output logic               in_ready,
  output logic               pkt_rd_en,
  output logic [ADDR_W-1:0]  pkt_rd_addr,
  input  logic [31:0]        pkt_rd_data,
  input  logic               cfg_filter_en,
  input  logic [RT_N*32-1:0] cfg_route_key,
  input  logic [RT_N-1:0]    cfg_route_port,
  input  logic [RT_N-1:0]    cfg_route_vld,
  input  logic [BL_N*32-1:0] cfg_block_key,
  input  logic [BL_N-1:0]    cfg_block_vld,
  output logic               out_valid,
  output logic [1:0]         out_dest,
  output logic [ADDR_W-1:0]  out_addr,
  output logic [31:0]        out_hdr_w2
);

  localparam int SA_W = $clog2(STORE_DEPTH);
  localparam int KW   = $clog2(HDR_WORDS + 1);
  localparam logic [SA_W-1:0] SPARE_IDX = SA_W'(STORE_DEPTH - 1);
  localparam logic [SA_W-1:0] W2_IDX    = SA_W'(CSUM_WORD);
  localparam logic [SA_W-1:0] LAST_IDX  = SA_W'(HDR_WORDS - 1);
  localparam logic [KW-1:0]   LAST_K    = KW'(HDR_WORDS - 1);
  localparam logic [7:0]      VER_IHL   = 8'h45;

  // reset release
  logic rst_sync_n;
  fwd_rst_sync #(.STAGES(2)) u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  // state and datapath registers
  fwd_state_t        state_q, state_d;
  logic [KW-1:0]     k_q, k_d;
  logic [ADDR_W-1:0] base_q;
  logic [15:0]       sum_q, sum_d, psum_q, psum_d;
  logic [15:0]       w2hi_q;
  logic [31:0]       src_q, dst_q;
  logic [15:0]       ncsum_q, ncsum_d;
  dest_t             dest_q, dest_d;

  // enables
  logic k_en, base_en, sum_en, psum_en, hi_en, src_en, dst_en, ncsum_en, dest_en;

  // store ports
  logic            st_we;
  logic [3:0]      st_be;
  logic [SA_W-1:0] st_waddr, st_raddr;
  logic [31:0]     st_wdata, st_rdata;

  // control helpers
  logic        accept, in_fetch, hdr_ok, first_bad, add_en, rd_is_w2;
  logic        csum_ok, ttl_live, blocked, rt_hit, rt_port, fwd_ok;
  logic [7:0]  ttl_new;
  logic [RT_N-1:0] rt_match;
  logic [BL_N-1:0] blk_match;

  hdr_store #(.DW(32), .DEPTH(STORE_DEPTH)) u_store (
    .clk(clk), .we(st_we), .be(st_be), .waddr(st_waddr), .wdata(st_wdata),
    .raddr(st_raddr), .rdata(st_rdata)
  );

  match_table #(.N(RT_N), .W(32)) u_route (
    .key(dst_q), .entry_key(cfg_route_key), .entry_vld(cfg_route_vld), .match(rt_match)
  );

  match_table #(.N(BL_N), .W(32)) u_block (
    .key(src_q), .entry_key(cfg_block_key), .entry_vld(cfg_block_vld), .match(blk_match)
  );

  // lowest-index route hit picks the port
  always_comb begin
    rt_port = 1'b0;
    for (int i = RT_N - 1; i >= 0; i--) begin
      if (rt_match[i]) rt_port = cfg_route_port[i];
    end
  end
  assign rt_hit = |rt_match;

  // input side and packet memory reads
  assign in_ready    = (state_q == S_IDLE) && rst_sync_n;
  assign accept      = in_valid && in_ready;
  assign in_fetch    = (state_q == S_FETCH);
  assign hdr_ok      = (pkt_rd_data[31:24] == VER_IHL);
  assign first_bad   = in_fetch && (k_q == '0) && !hdr_ok;
  assign pkt_rd_en   = accept || (in_fetch && (k_q != LAST_K) && !first_bad);
  assign pkt_rd_addr = accept ? in_addr : base_q + ADDR_W'(k_q) + ADDR_W'(1);

  // local store port control
  always_comb begin
    st_we    = 1'b0;
    st_be    = 4'h0;
    st_waddr = W2_IDX;
    st_wdata = pkt_rd_data;
    st_raddr = SPARE_IDX;
    unique case (state_q)
      S_FETCH: begin
        st_we    = 1'b1;
        st_be    = 4'hF;
        st_waddr = SA_W'(k_q);
        st_raddr = (k_q == '0) ? SPARE_IDX : SA_W'(k_q - KW'(1));
      end
      S_SUM:     st_raddr = LAST_IDX;
      S_WB_TTL: begin
        st_we    = 1'b1;
        st_be    = 4'b1000;
        st_wdata = {ttl_new, 24'h0};
      end
      S_WB_CSUM: begin
        st_we    = 1'b1;
        st_be    = 4'b0011;
        st_wdata = {16'h0, ncsum_q};
      end
      S_CHECK, S_DONE: st_raddr = W2_IDX;
      default: ;
    endcase
  end

  // running sums fed from the read port
  assign add_en   = (in_fetch && (k_q != '0)) || (state_q == S_SUM);
  assign rd_is_w2 = (st_raddr == W2_IDX);
  assign sum_d    = accept ? 16'h0 : oc_add(oc_add(sum_q,  st_rdata[31:16]), st_rdata[15:0]);
  assign psum_d   = accept ? 16'h0 : oc_add(oc_add(psum_q, st_rdata[31:16]), st_rdata[15:0]);
  assign sum_en   = accept || add_en;
  assign psum_en  = accept || (add_en && !rd_is_w2);

  // field captures from the incoming words
  assign hi_en  = in_fetch && (k_q == KW'(2));
  assign src_en = in_fetch && (k_q == KW'(3));
  assign dst_en = in_fetch && (k_q == KW'(4));

  // checks
  assign csum_ok  = (sum_q == 16'hFFFF);
  assign ttl_live = (w2hi_q[15:8] > 8'd1);
  assign blocked  = cfg_filter_en && (|blk_match);
  assign fwd_ok   = csum_ok && ttl_live && !blocked && rt_hit;
  assign ttl_new  = w2hi_q[15:8] - 8'd1;

  assign ncsum_en = (state_q == S_WB_TTL);
  assign ncsum_d  = ~oc_add(psum_q, {ttl_new, w2hi_q[7:0]});

  assign dest_en = first_bad || (state_q == S_CHECK);
  assign dest_d  = ((state_q == S_CHECK) && fwd_ok) ? (rt_port ? DEST_B : DEST_A) : DEST_DROP;

  assign base_en = accept;
  assign k_en    = accept || in_fetch;
  assign k_d     = accept ? '0 : k_q + KW'(1);

  // next state
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:    if (accept) state_d = S_FETCH;
      S_FETCH: begin
        if (first_bad)            state_d = S_DONE;
        else if (k_q == LAST_K)   state_d = S_SUM;
      end
      S_SUM:     state_d = S_CHECK;
      S_CHECK:   state_d = fwd_ok ? S_WB_TTL : S_DONE;
      S_WB_TTL:  state_d = S_WB_CSUM;
      S_WB_CSUM: state_d = S_DONE;
      S_DONE:    state_d = S_IDLE;
      default:   state_d = S_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= S_IDLE;
      k_q     <= '0;
      base_q  <= '0;
      sum_q   <= '0;
      psum_q  <= '0;
      w2hi_q  <= '0;
      src_q   <= '0;
      dst_q   <= '0;
      ncsum_q <= '0;
      dest_q  <= DEST_DROP;
    end else begin
      state_q <= state_d;
      if (k_en)     k_q     <= k_d;
      if (base_en)  base_q  <= in_addr;
      if (sum_en)   sum_q   <= sum_d;
      if (psum_en)  psum_q  <= psum_d;
      if (hi_en)    w2hi_q  <= pkt_rd_data[31:16];
      if (src_en)   src_q   <= pkt_rd_data;
      if (dst_en)   dst_q   <= pkt_rd_data;
      if (ncsum_en) ncsum_q <= ncsum_d;
      if (dest_en)  dest_q  <= dest_d;
    end
  end

  // result
  assign out_valid  = (state_q == S_DONE);
  assign out_dest   = dest_q;
  assign out_addr   = base_q;
  assign out_hdr_w2 = st_rdata;

endmodule

// File: rtl/ipv4_fwd_chk.sv
module ipv4_fwd_chk (
  input logic        clk,
  input logic        rst_sync_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        pkt_rd_en,
  input logic [31:0] pkt_rd_data,
  input logic        out_valid,
  input logic [1:0]  out_dest,
  input logic [31:0] out_hdr_w2,
  input logic        st_we,
  input logic [3:0]  st_waddr,
  input logic [3:0]  st_raddr
);

  // R2
  early_reject_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(in_valid && in_ready) && (pkt_rd_data[31:24] != 8'h45)) |-> !pkt_rd_en);

  // R8
  out_pulse_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_valid |=> !out_valid);

  // R8
  dest_code_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_valid |-> (out_dest != 2'b11));

  // R1
  busy_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_valid |-> !in_ready);

  // R10
  no_rw_clash_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    st_we |-> (st_raddr != st_waddr));

  // R4
  live_ttl_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && (out_dest != 2'b10)) |-> (out_hdr_w2[31:24] != 8'h00));

endmodule

bind ipv4_fwd_engine ipv4_fwd_chk u_chk (
  .clk(clk),
  .rst_sync_n(rst_sync_n),
  .in_valid(in_valid),
  .in_ready(in_ready),
  .pkt_rd_en(pkt_rd_en),
  .pkt_rd_data(pkt_rd_data),
  .out_valid(out_valid),
  .out_dest(out_dest),
  .out_hdr_w2(out_hdr_w2),
  .st_we(st_we),
  .st_waddr(st_waddr),
  .st_raddr(st_raddr)
);

// File: tb/tb_ipv4_fwd_engine.sv
`timescale 1ns/1ps
module tb_ipv4_fwd_engine;

  localparam int ADDR_W = 8;
  localparam int RT_N   = 8;
  localparam int BL_N   = 4;

  typedef logic [4:0][31:0] hdr_t;
  typedef struct {
    logic [1:0]  dest;
    logic [31:0] w2;
    bit          chk_w2;
    int          lat;
    int          reads;
    logic [7:0]  addr;
    int          acc;
    string       req;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid;
  logic [ADDR_W-1:0] in_addr;
  logic in_ready;
  logic pkt_rd_en;
  logic [ADDR_W-1:0] pkt_rd_addr;
  logic [31:0] pkt_rd_data;
  logic cfg_filter_en;
  logic [RT_N*32-1:0] cfg_route_key;
  logic [RT_N-1:0] cfg_route_port, cfg_route_vld;
  logic [BL_N*32-1:0] cfg_block_key;
  logic [BL_N-1:0] cfg_block_vld;
  logic out_valid;
  logic [1:0] out_dest;
  logic [ADDR_W-1:0] out_addr;
  logic [31:0] out_hdr_w2;

  logic [31:0] pmem [256];
  int cyc = 0;
  int rd_cnt = 0;
  int rd_mark = 0;
  int total = 0;
  int bad = 0;
  bit finished = 0;
  exp_t expq [$];

  always #4 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge clk) if (pkt_rd_en) rd_cnt <= rd_cnt + 1;
  always @(posedge clk) if (pkt_rd_en) pkt_rd_data <= pmem[pkt_rd_addr];

  ipv4_fwd_engine #(.ADDR_W(ADDR_W), .RT_N(RT_N), .BL_N(BL_N), .STORE_DEPTH(16)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr), .in_ready(in_ready),
    .pkt_rd_en(pkt_rd_en), .pkt_rd_addr(pkt_rd_addr), .pkt_rd_data(pkt_rd_data),
    .cfg_filter_en(cfg_filter_en), .cfg_route_key(cfg_route_key),
    .cfg_route_port(cfg_route_port), .cfg_route_vld(cfg_route_vld),
    .cfg_block_key(cfg_block_key), .cfg_block_vld(cfg_block_vld),
    .out_valid(out_valid), .out_dest(out_dest), .out_addr(out_addr), .out_hdr_w2(out_hdr_w2)
  );

  function automatic logic [15:0] ocs(input logic [15:0] a, input logic [15:0] b);
    logic [16:0] t;
    t = {1'b0, a} + {1'b0, b};
    return t[15:0] + {15'd0, t[16]};
  endfunction

  function automatic logic [15:0] sum_words(input hdr_t h, input logic [15:0] w2hi);
    logic [15:0] s;
    s = 16'h0;
    for (int i = 0; i < 5; i++) begin
      if (i != 2) s = ocs(ocs(s, h[i][31:16]), h[i][15:0]);
    end
    return ocs(s, w2hi);
  endfunction

  function automatic hdr_t mk(input logic [7:0] vihl, input logic [7:0] ttl,
                              input logic [31:0] src, input logic [31:0] dst, input bit bad_csum);
    hdr_t h;
    logic [15:0] c;
    h[0] = {vihl, 8'h00, 16'd20};
    h[1] = {16'h1234, 16'h4000};
    h[2] = {ttl, 8'h11, 16'h0};
    h[3] = src;
    h[4] = dst;
    c = ~sum_words(h, {ttl, 8'h11});
    if (bad_csum) c = c ^ 16'h0101;
    h[2][15:0] = c;
    return h;
  endfunction

  function automatic logic [31:0] fwd_w2(input hdr_t h);
    logic [15:0] nh;
    nh = {h[2][31:24] - 8'd1, h[2][23:16]};
    return {nh, ~sum_words(h, nh)};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
    end
  endtask

  // driver: offers one header and pushes its expected result
  task automatic send(input logic [7:0] base, input hdr_t h, input logic [1:0] dest,
                      input int lat, input int reads, input string req);
    exp_t e;
    for (int i = 0; i < 5; i++) pmem[base + 8'(i)] = h[i];
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_addr  = base;
    @(negedge clk);
    in_valid = 1'b0;
    e.dest   = dest;
    e.w2     = fwd_w2(h);
    e.chk_w2 = (dest != 2'b10);
    e.lat    = lat;
    e.reads  = reads;
    e.addr   = base;
    e.acc    = cyc;
    e.req    = req;
    expq.push_back(e);
    while (expq.size() != 0) @(negedge clk);
  endtask

  // monitor: pops and compares every result pulse
  task automatic monitor();
    exp_t e;
    forever begin
      @(negedge clk);
      if (rst_n && out_valid) begin
        if (expq.size() == 0) begin
          check(0, "R8", "unexpected result", 32'(out_dest), 32'h0);
        end else begin
          e = expq.pop_front();
          check(out_dest == e.dest, e.req, "dest (R8 code)", 32'(out_dest), 32'(e.dest));
          check(out_addr == e.addr, "R8", "out_addr", 32'(out_addr), 32'(e.addr));
          check((cyc - e.acc) == e.lat, e.req, "latency (R9)", 32'(cyc - e.acc), 32'(e.lat));
          check((rd_cnt - rd_mark) == e.reads, e.req, "reads (R1)", 32'(rd_cnt - rd_mark), 32'(e.reads));
          if (e.chk_w2)
            check(out_hdr_w2 == e.w2, "R7", "updated word 2", out_hdr_w2, e.w2);
          rd_mark = rd_cnt;
        end
      end
    end
  endtask

  task automatic watchdog();
    repeat (20000) @(posedge clk);
    check(0, "R9", "watchdog expired", 32'(expq.size()), 32'h0);
    summary();
    $finish;
  endtask

  initial begin
    rst_n         = 1'b0;
    in_valid      = 1'b0;
    in_addr       = '0;
    cfg_filter_en = 1'b0;
    for (int i = 0; i < RT_N; i++) begin
      cfg_route_key[i*32 +: 32] = 32'h0A000100 + 32'(i);
      cfg_route_port[i]         = i[0];
    end
    cfg_route_vld = 8'h7F;
    cfg_block_key = '0;
    cfg_block_key[31:0] = 32'hC0A80005;
    cfg_block_vld = 4'b0001;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(in_ready == 1'b1, "R1", "in_ready after reset", 32'(in_ready), 32'h1);
    check(out_valid == 1'b0, "R8", "out_valid after reset", 32'(out_valid), 32'h0);
    check(pkt_rd_en == 1'b0, "R1", "pkt_rd_en after reset", 32'(pkt_rd_en), 32'h0);

    fork
      monitor();
      watchdog();
    join_none

    // R5 port A, R7 rewrite, R9 latency
    send(8'h10, mk(8'h45, 8'd64, 32'hC0A80001, 32'h0A000100, 0), 2'b00, 9, 5, "R5");
    // R4 boundary TTL 2 forwards, R5 port B
    send(8'h20, mk(8'h45, 8'd2, 32'hC0A80001, 32'h0A000101, 0), 2'b01, 9, 5, "R4");
    // R2 wrong header length
    send(8'h30, mk(8'h46, 8'd64, 32'hC0A80001, 32'h0A000100, 0), 2'b10, 1, 1, "R2");
    // R2 wrong version
    send(8'h40, mk(8'h55, 8'd64, 32'hC0A80001, 32'h0A000100, 0), 2'b10, 1, 1, "R2");
    // R3 corrupted checksum
    send(8'h50, mk(8'h45, 8'd64, 32'hC0A80001, 32'h0A000100, 1), 2'b10, 7, 5, "R3");
    // R4 TTL 1 and 0
    send(8'h60, mk(8'h45, 8'd1, 32'hC0A80001, 32'h0A000100, 0), 2'b10, 7, 5, "R4");
    send(8'h70, mk(8'h45, 8'd0, 32'hC0A80001, 32'h0A000100, 0), 2'b10, 7, 5, "R4");
    // R5 invalid entry and absent address both miss
    send(8'h80, mk(8'h45, 8'd64, 32'hC0A80001, 32'h0A000107, 0), 2'b10, 7, 5, "R5");
    send(8'h90, mk(8'h45, 8'd64, 32'hC0A80001, 32'h0B000000, 0), 2'b10, 7, 5, "R5");
    // R6 filter off: blocked source still forwards
    send(8'hA0, mk(8'h45, 8'd64, 32'hC0A80005, 32'h0A000100, 0), 2'b00, 9, 5, "R6");
    cfg_filter_en = 1'b1;
    // R6 filter on: blocked source discarded
    send(8'hB0, mk(8'h45, 8'd64, 32'hC0A80005, 32'h0A000100, 0), 2'b10, 7, 5, "R6");
    // R9 filter on, clean source: same latency as unfiltered
    send(8'hC0, mk(8'h45, 8'd33, 32'hC0A80009, 32'h0A000103, 0), 2'b01, 9, 5, "R9");
    cfg_filter_en = 1'b0;
    // R3 all-ones payload halves
    send(8'hD0, mk(8'h45, 8'd255, 32'hFFFFFFFF, 32'h0A000102, 0), 2'b00, 9, 5, "R3");

    repeat (4) @(negedge clk);
    check(out_valid == 1'b0, "R8", "idle after last packet", 32'(out_valid), 32'h0);
    summary();
    $finish;
  end

endmodule